// File: doc/BRIEF.md
# Four-Byte Serial Instruction Shifter

This block is the host end of a three-wire synchronous link (serial clock, host-to-target data, target-to-host data) used to send programming instructions to a target device. One pulse on `start` loads a 32-bit instruction. The block then shifts it out as four bytes, most significant bit first, while it collects the 32 bits the target sends back over the same clock pulses. When the last bit has gone out, the block raises `done` for one cycle. The collected word appears on `rsp_word`.

The target samples incoming data on the rising edge of the serial clock and updates its outgoing data on the falling edge. The block therefore changes `mosi` only while the clock goes low. It samples `miso` at the rising edge, a full half period after the target last changed it. The byte collected during the third outgoing byte is brought out separately on `echo_byte`, because a target in step with the host repeats its second received byte there. A controller above this block decides what to send, judges the reply and handles target reset and delays.

Top module: `isp_shift4`

## Requirements
- R1: After reset, and whenever no transfer is running, `sck` is 0, `mosi` is 0, `busy` is 0 and `done` is 0.
- R2: The instruction is sent most significant bit first: the value of `mosi` at the k-th rising edge of `sck` (k = 1..32) equals `instr[32-k]`, as captured at the accepted start. Byte 1 is `instr[31:24]` and byte 4 is `instr[7:0]`.
- R3: `miso` is sampled at each rising edge of `sck`. The first sampled bit lands in `rsp_word[31]` and the last in `rsp_word[0]`. `rsp_word` is valid from `done` and holds until the next accepted start.
- R4: Every transfer produces exactly 32 rising edges of `sck`, with no early end.
- R5: `echo_byte` carries the 8 bits sampled during the third byte, i.e. `rsp_word[15:8]`. It is updated when that byte's last falling edge occurs, so it is already valid while byte 4 is being shifted.
- R6: Each low and high phase of `sck` lasts `HALF_DIV` clock cycles (`HALF_DIV` >= 2). The first rising edge comes `HALF_DIV` cycles after `busy` rises, so consecutive rising edges are `2*HALF_DIV` cycles apart.
- R7: `busy` rises on the clock edge that accepts `start` and stays high for exactly `64*HALF_DIV` cycles. It falls together with the last falling edge of `sck`. `done` is a single-cycle pulse in the cycle `busy` falls.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The transfer in progress keeps its instruction, its length and its timing.
- R9: While a transfer runs, `mosi` changes only on a cycle in which `sck` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer when idle (single-cycle pulse) |
| instr | input | 32 | Instruction to send, sampled when start is accepted |
| miso | input | 1 | Serial data from the target |
| sck | output | 1 | Serial clock to the target, idles low |
| mosi | output | 1 | Serial data to the target |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer ends |
| rsp_word | output | 32 | The four bytes returned by the target, byte 1 in bits 31:24 |
| echo_byte | output | 8 | Byte returned while the third byte was sent |

## Verification
A behavioural target shifts out a chosen reply on each falling clock edge and records `mosi` on each rising edge. Each vector pairs an instruction with a reply.
- All-zero and all-one words show whether any bit is stuck.
- Alternating patterns expose swapped neighbour bits.
- Asymmetric words such as 0x80000001 and 0x01234567 reveal bit-order and byte-order reversals on both directions.
- A programming-enable style exchange, with 0x53 returned in byte 3, confirms the echo byte and that it is ready before byte 4 finishes.

Directed cases then cover the reset and idle levels, a start pulse injected mid-transfer, and the phase lengths of the serial clock.

// File: rtl/isp_shift4_pkg.sv
// Package: shared constants and types for the four-byte serial instruction shifter.
// Assumes every instruction is exactly four bytes, sent first byte first.
package isp_shift4_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_BYTES  = 4;
    localparam int WORD_W     = BYTE_W * NUM_BYTES;
    localparam int BIT_IDX_W  = $clog2(WORD_W);
    // Zero-based index of the byte whose reply is exposed as the echo (third byte).
    localparam int ECHO_BYTE  = 2;
    // Bit index of the final bit of the echo byte within the transfer.
    localparam int ECHO_LAST  = (ECHO_BYTE + 1) * BYTE_W - 1;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/isp_sck_gen.sv
// Serial clock generator: while run is high, toggles sck every HALF_DIV system
// clocks, starting low, and flags the cycle before each rising and falling edge.
// Assumes HALF_DIV >= 2; restart forces a fresh low phase.
module isp_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic sck,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    generate
        if (HALF_DIV < 2) begin : g_bad_div
            $error("isp_sck_gen: HALF_DIV must be at least 2");
        end
    endgenerate

    logic [CNT_W-1:0] cnt_q;
    logic             sck_q;
    logic             expire;

    // Phase end: the half period has run its full length.
    assign expire    = run && !restart && (cnt_q == CNT_LAST);
    assign rise_tick = expire && !sck_q;
    assign fall_tick = expire && sck_q;
    assign sck       = sck_q;

    // Half-period counter and serial clock register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (expire) begin
            cnt_q <= '0;
            sck_q <= !sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the clock never toggles on two consecutive cycles.
    p_no_fast_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$stable(sck_q)) |=> $stable(sck_q));
endmodule

// File: rtl/isp_shift_core.sv
// Shift datapath: holds the outgoing word and shifts it MSB first on each
// falling tick; collects incoming bits on each rising tick; counts bits.
// Assumes ticks come only while a transfer runs and never in the same cycle.
module isp_shift_core
    import isp_shift4_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  word_t    load_word,
    input  logic     rise_tick,
    input  logic     fall_tick,
    input  logic     miso,
    output logic     tx_bit,
    output word_t    rx_word,
    output bit_idx_t bit_idx,
    output logic     last_bit
);
    localparam bit_idx_t LAST_IDX = BIT_IDX_W'(WORD_W - 1);

    word_t    tx_q;
    word_t    rx_q;
    bit_idx_t idx_q;

    assign tx_bit   = tx_q[WORD_W-1];
    assign rx_word  = rx_q;
    assign bit_idx  = idx_q;
    assign last_bit = (idx_q == LAST_IDX);

    // Outgoing register and bit counter: load on start, advance on falling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            tx_q  <= load_word;
            idx_q <= '0;
        end else if (fall_tick && !last_bit) begin
            tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    // Incoming register: take the target's bit at each rising tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (rise_tick) begin
            rx_q <= {rx_q[WORD_W-2:0], miso};
        end
    end

    // R3: the reply only moves at rising ticks.
    p_rx_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_tick |=> $stable(rx_q));
    // R2: a load places the whole instruction, first bit on top.
    p_tx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tx_q == $past(load_word)));
endmodule

// File: rtl/isp_shift4.sv
// Top: four-byte serial instruction shifter. Accepts start when idle, runs one
// 32-bit full-duplex transfer, pulses done and holds the reply and echo byte.
// Assumes the target samples on rising and drives on falling serial clock edges.
module isp_shift4
    import isp_shift4_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] instr,
    input  logic        miso,
    output logic        sck,
    output logic        mosi,
    output logic        busy,
    output logic        done,
    output logic [31:0] rsp_word,
    output logic [7:0]  echo_byte
);
    localparam bit_idx_t ECHO_IDX = BIT_IDX_W'(ECHO_LAST);

    logic     busy_q;
    logic     done_q;
    byte_t    echo_q;
    logic     accept;
    logic     finish;
    logic     rise_tick;
    logic     fall_tick;
    logic     tx_bit;
    logic     last_bit;
    word_t    rx_word;
    bit_idx_t bit_idx;

    assign accept = start && !busy_q;
    assign finish = fall_tick && last_bit;

    isp_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_q),
        .restart   (accept),
        .sck       (sck),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    isp_shift_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (instr),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .miso      (miso),
        .tx_bit    (tx_bit),
        .rx_word   (rx_word),
        .bit_idx   (bit_idx),
        .last_bit  (last_bit)
    );

    // Transfer state: busy from accepted start to the final falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q <= 1'b1;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Echo capture: keep the third reply byte once its last bit is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_q <= '0;
        end else if (fall_tick && (bit_idx == ECHO_IDX)) begin
            echo_q <= rx_word[BYTE_W-1:0];
        end
    end

    assign mosi      = busy_q && tx_bit;
    assign busy      = busy_q;
    assign done      = done_q;
    assign rsp_word  = rx_word;
    assign echo_byte = echo_q;

    // R1: the serial clock rests low whenever no transfer runs.
    p_sck_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck);
    // R7: done lasts one cycle and coincides with the end of busy.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $fell(busy_q)));
    // R9: outgoing data moves only with a falling serial clock.
    p_mosi_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$fell(sck)) |-> $stable(mosi));
    // R8: a start during a transfer never rewinds the bit count.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> (bit_idx >= $past(bit_idx)));
endmodule

// File: tb/isp_shift4_tb.sv
`timescale 1ns/1ps
module isp_shift4_tb;
    localparam int HALF = 3;
    localparam int NVEC = 6;
    // {instr, target reply}
    localparam logic [63:0] VEC [0:NVEC-1] = '{
        {32'hAC53_0000, 32'h00AC_5300},
        {32'h0000_0000, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'h0000_0000},
        {32'hAAAA_5555, 32'h5555_AAAA},
        {32'h8000_0001, 32'h0123_4567},
        {32'h0123_4567, 32'h8000_0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        miso;
    logic        sck, mosi, busy, done;
    logic [31:0] rsp_word;
    logic [7:0]  echo_byte;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    // target model and observers
    logic [31:0] slv_sr = '0;
    logic [31:0] cap = '0;
    int cyc = 0, start_cyc = 0, last_rise = 0, rises = 0;
    int first_gap = 0, gap_min = 0, gap_max = 0;
    logic [7:0] echo_snap = '0;

    isp_shift4 #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(busy), .done(done),
        .rsp_word(rsp_word), .echo_byte(echo_byte)
    );

    always #10 clk = ~clk;
    assign miso = slv_sr[31];

    always @(posedge clk) cyc = cyc + 1;
    always @(posedge busy) start_cyc = cyc;
    always @(negedge sck) slv_sr = {slv_sr[30:0], 1'b0};
    always @(posedge sck) begin
        cap = {cap[30:0], mosi};
        rises = rises + 1;
        if (rises == 1) first_gap = cyc - start_cyc;
        else begin
            if (cyc - last_rise < gap_min) gap_min = cyc - last_rise;
            if (cyc - last_rise > gap_max) gap_max = cyc - last_rise;
        end
        last_rise = cyc;
        if (rises == 25) echo_snap = echo_byte;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one transfer; optionally pulse start with alt_instr at busy cycle inj_at.
    task automatic xfer(input logic [31:0] ins, input logic [31:0] rsp,
                        input int inj_at, input logic [31:0] alt_instr,
                        output int dur, output logic done_at_end);
        @(negedge clk);
        instr = ins; slv_sr = rsp; cap = '0; rises = 0;
        gap_min = 1000; gap_max = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dur = 1;
        while (busy) begin
            if (dur == inj_at) begin instr = alt_instr; start = 1'b1; end
            @(negedge clk);
            start = 1'b0;
            if (busy) dur++;
        end
        done_at_end = done;
    endtask

    initial begin
        int dur;
        logic dn;
        instr = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R1: reset levels, with an all-ones instruction waiting
        chk("R1 sck in reset", {63'd0, sck}, 64'd0);
        chk("R1 busy/done in reset", {62'd0, busy, done}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle mosi low", {63'd0, mosi}, 64'd0);
        chk("R1 idle sck low", {63'd0, sck}, 64'd0);

        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][63:32], VEC[v][31:0], -1, '0, dur, dn);
            chk("R2 mosi bit order", {32'd0, cap}, {32'd0, VEC[v][63:32]});
            chk("R3 reply word", {32'd0, rsp_word}, {32'd0, VEC[v][31:0]});
            chk("R4 sck pulse count", 64'(rises), 64'd32);
            chk("R5 echo byte", {56'd0, echo_byte}, {56'd0, VEC[v][15:8]});
            chk("R5 echo ready in byte 4", {56'd0, echo_snap}, {56'd0, VEC[v][15:8]});
            chk("R6 first rise delay", 64'(first_gap), 64'(HALF));
            chk("R6 rise spacing", {32'(gap_min), 32'(gap_max)}, {32'(2*HALF), 32'(2*HALF)});
            chk("R7 busy length", 64'(dur), 64'(64*HALF));
            chk("R7 done with busy fall", {63'd0, dn}, 64'd1);
            @(negedge clk);
            chk("R7 done one cycle", {63'd0, done}, 64'd0);
            repeat (4) @(negedge clk);
            chk("R1 idle after transfer", {62'd0, sck, mosi}, 64'd0);
            chk("R3 reply held", {32'd0, rsp_word}, {32'd0, VEC[v][31:0]});
        end

        // R8: a start injected mid-transfer is ignored
        xfer(32'hC3A5_0F96, 32'h1357_9BDF, 40, 32'h0000_FFFF, dur, dn);
        chk("R8 instruction kept", {32'd0, cap}, 64'hC3A5_0F96);
        chk("R8 length kept", 64'(dur), 64'(64*HALF));
        chk("R8 pulse count kept", 64'(rises), 64'd32);
        chk("R8 reply intact", {32'd0, rsp_word}, 64'h1357_9BDF);
        repeat (3) @(negedge clk);
        chk("R8 no second transfer", {63'd0, busy}, 64'd0);

        // R3: next start begins from a fresh reply
        xfer(32'h5A5A_A5A5, 32'hDEAD_BEEF, -1, '0, dur, dn);
        chk("R3 back-to-back reply", {32'd0, rsp_word}, 64'hDEAD_BEEF);
        chk("R2 back-to-back instr", {32'd0, cap}, 64'h5A5A_A5A5);

        // R1: reset mid-transfer returns to idle levels
        @(negedge clk); instr = 32'hFFFF_FFFF; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-transfer", {61'd0, busy, sck, mosi}, 64'd0);
        rst_n = 1'b1;

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule